// File: doc/BRIEF.md
# Two-Phase Processor Data Bus Interface

This block sits between a processor's bidirectional external data pins and three internal buses: a low address bus, a high address bus and an internal data bus. It holds two registers. The input latch captures the pins. The output register holds the byte that a write cycle places on the pins.

The machine cycle is split into two non-overlapping phases, and each arrives as a qualifying enable on one fast system clock. In the first phase, three select strobes put the input latch onto any mix of the three internal buses. Other drivers inside the processor may put values on those buses at the same time. The output register then takes whatever the internal data bus carries. In the second phase, every internal bus is pulled back to all ones. The input latch samples the pins, and on a write the pins are driven from the output register.

The buses are modelled as precharged, pull-down-only wires: any driver can pull a bit low, and no driver can pull one high. When no phase is active, the buses rest at all ones and no register changes.

Top module: `twophase_dbus_if`

## Requirements
- R1: After reset, the input latch and the output register both hold 0x00. The output register shows on `pad_data_out`, and the input latch appears on a bus as soon as a strobe selects it.
- R2: While `phi1` is high and `sel_lo_addr` is set, the input latch contributes to `lo_addr_bus`.
- R3: While `phi1` is high and `sel_hi_addr` is set, the input latch contributes to `hi_addr_bus`.
- R4: While `phi1` is high and `sel_data` is set, the input latch contributes to `data_bus`.
- R5: On a clock edge where `phi1` is high, the output register loads the value `data_bus` carries in that cycle. On every other edge it keeps its value.
- R6: `pad_oe` is 1 only when `phi2` is high and `pad_rw` is 0 (0 means write, 1 means read). `pad_data_out` always shows the output register.
- R7: On a clock edge where `phi2` is high, the input latch loads `pad_data_in`. On every other edge it keeps its value.
- R8: While `phi2` is high, all three internal buses read all ones, whatever the strobes and external enables are.
- R9: In `phi1`, each bus is the bitwise AND of all of its enabled sources. The sources are the input latch, when its strobe is set, and each external driver whose enable bit is set. With no source enabled, the bus reads all ones.
- R10: `phi1` and `phi2` are never high together. When neither is high, every bus reads all ones and neither register changes, whatever appears on the pins or the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi1 | input | 1 | First-phase enable |
| phi2 | input | 1 | Second-phase enable |
| pad_rw | input | 1 | 1 = read, 0 = write |
| sel_lo_addr | input | 1 | Put the input latch on the low address bus |
| sel_hi_addr | input | 1 | Put the input latch on the high address bus |
| sel_data | input | 1 | Put the input latch on the internal data bus |
| ext_lo_en | input | EXT_SRC | Enables of the other low address bus drivers |
| ext_lo_val | input | EXT_SRC*W | Values of the other low address bus drivers, packed |
| ext_hi_en | input | EXT_SRC | Enables of the other high address bus drivers |
| ext_hi_val | input | EXT_SRC*W | Values of the other high address bus drivers, packed |
| ext_db_en | input | EXT_SRC | Enables of the other data bus drivers |
| ext_db_val | input | EXT_SRC*W | Values of the other data bus drivers, packed |
| pad_data_in | input | W | Value sensed on the data pins |
| pad_data_out | output | W | Value to drive on the data pins |
| pad_oe | output | 1 | Data pin output enable |
| lo_addr_bus | output | W | Low address bus |
| hi_addr_bus | output | W | High address bus |
| data_bus | output | W | Internal data bus |

## Verification
The bench builds the block with its defaults: W = 8 and EXT_SRC = 2. That gives every bus three possible pull-down sources, so the random stimulus reaches cases where the latch and both external drivers combine on one bus, and also cases where no source is enabled. An eight-bit width keeps sparse-zero AND patterns in easy reach. The random stream mixes idle, first-phase and second-phase cycles, so latch-to-bus-to-output-register chains form on their own. Directed cases cover the all-strobes precharge case and the idle-cycle holds.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ONE  = 2'd1,
    PH_TWO  = 2'd2,
    PH_BAD  = 2'd3
  } dbi_phase_e;

  function automatic dbi_phase_e phase_of(input logic p1, input logic p2);
    return dbi_phase_e'({p2, p1});
  endfunction
endpackage

// File: rtl/dbi_bus_merge.sv
module dbi_bus_merge #(
  parameter int W = 8,
  parameter int N = 3
) (
  input  logic           drive_ph,
  input  logic [N-1:0]   src_en,
  input  logic [N*W-1:0] src_val,
  output logic [W-1:0]   bus
);
  logic [W-1:0] term [N];

  // Each source either pulls bits low or leaves the precharged ones alone.
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_term
      assign term[gi] = (drive_ph && src_en[gi]) ? src_val[gi*W +: W] : '1;
    end
  endgenerate

  always_comb begin
    bus = '1;
    for (int i = 0; i < N; i++) begin
      bus = bus & term[i];
    end
  end
endmodule

// File: rtl/dbi_en_reg.sv
module dbi_en_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/twophase_dbus_if.sv
module twophase_dbus_if
  import dbi_pkg::*;
#(
  parameter int W       = 8,
  parameter int EXT_SRC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 phi1,
  input  logic                 phi2,
  input  logic                 pad_rw,
  input  logic                 sel_lo_addr,
  input  logic                 sel_hi_addr,
  input  logic                 sel_data,
  input  logic [EXT_SRC-1:0]   ext_lo_en,
  input  logic [EXT_SRC*W-1:0] ext_lo_val,
  input  logic [EXT_SRC-1:0]   ext_hi_en,
  input  logic [EXT_SRC*W-1:0] ext_hi_val,
  input  logic [EXT_SRC-1:0]   ext_db_en,
  input  logic [EXT_SRC*W-1:0] ext_db_val,
  input  logic [W-1:0]         pad_data_in,
  output logic [W-1:0]         pad_data_out,
  output logic                 pad_oe,
  output logic [W-1:0]         lo_addr_bus,
  output logic [W-1:0]         hi_addr_bus,
  output logic [W-1:0]         data_bus
);
  localparam int NSRC = EXT_SRC + 1;

  dbi_phase_e   phase;
  logic         drive_ph;
  logic         sample_ph;
  logic [W-1:0] in_latch_q;
  logic [W-1:0] out_reg_q;

  always_comb begin
    phase     = phase_of(phi1, phi2);
    drive_ph  = (phase == PH_ONE);
    sample_ph = (phase == PH_TWO);
  end

  // Source slot 0 is the input latch; the slots above it are the external drivers.
  dbi_bus_merge #(.W(W), .N(NSRC)) u_lo_merge (
    .drive_ph (drive_ph),
    .src_en   ({ext_lo_en, sel_lo_addr}),
    .src_val  ({ext_lo_val, in_latch_q}),
    .bus      (lo_addr_bus)
  );

  dbi_bus_merge #(.W(W), .N(NSRC)) u_hi_merge (
    .drive_ph (drive_ph),
    .src_en   ({ext_hi_en, sel_hi_addr}),
    .src_val  ({ext_hi_val, in_latch_q}),
    .bus      (hi_addr_bus)
  );

  dbi_bus_merge #(.W(W), .N(NSRC)) u_db_merge (
    .drive_ph (drive_ph),
    .src_en   ({ext_db_en, sel_data}),
    .src_val  ({ext_db_val, in_latch_q}),
    .bus      (data_bus)
  );

  dbi_en_reg #(.W(W)) u_in_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sample_ph),
    .d     (pad_data_in),
    .q     (in_latch_q)
  );

  dbi_en_reg #(.W(W)) u_out_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (drive_ph),
    .d     (data_bus),
    .q     (out_reg_q)
  );

  always_comb begin
    pad_data_out = out_reg_q;
    pad_oe       = sample_ph && !pad_rw;
  end

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1 && phi2)); // R10

  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    phi2 |-> (lo_addr_bus == '1 && hi_addr_bus == '1 && data_bus == '1)); // R8

  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    phi1 |=> (out_reg_q == $past(data_bus))); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !phi1 |=> $stable(out_reg_q)); // R5

  AST_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    phi2 |=> (in_latch_q == $past(pad_data_in))); // R7

  AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |=> $stable(in_latch_q)); // R7

  AST_OE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> (!phi1 && !pad_rw)); // R6
endmodule

// File: tb/twophase_dbus_if_tb_top.sv
module twophase_dbus_if_tb_top;
  localparam int W  = 8;
  localparam int NE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phi1 = 1'b0, phi2 = 1'b0, pad_rw = 1'b1;
  logic sel_lo_addr = 1'b0, sel_hi_addr = 1'b0, sel_data = 1'b0;
  logic [NE-1:0]   ext_lo_en = '0, ext_hi_en = '0, ext_db_en = '0;
  logic [NE*W-1:0] ext_lo_val = '0, ext_hi_val = '0, ext_db_val = '0;
  logic [W-1:0]    pad_data_in = '0;
  logic [W-1:0]    pad_data_out, lo_addr_bus, hi_addr_bus, data_bus;
  logic            pad_oe;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_in;
  logic [W-1:0] m_out;

  always #2 clk = ~clk;

  twophase_dbus_if #(.W(W), .EXT_SRC(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2), .pad_rw(pad_rw),
    .sel_lo_addr(sel_lo_addr), .sel_hi_addr(sel_hi_addr), .sel_data(sel_data),
    .ext_lo_en(ext_lo_en), .ext_lo_val(ext_lo_val),
    .ext_hi_en(ext_hi_en), .ext_hi_val(ext_hi_val),
    .ext_db_en(ext_db_en), .ext_db_val(ext_db_val),
    .pad_data_in(pad_data_in), .pad_data_out(pad_data_out), .pad_oe(pad_oe),
    .lo_addr_bus(lo_addr_bus), .hi_addr_bus(hi_addr_bus), .data_bus(data_bus)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_bus(input logic p1, input logic p2, input logic sel,
      input logic [W-1:0] lat, input logic [NE-1:0] en, input logic [NE*W-1:0] val);
    logic [W-1:0] r = '1;
    if (p1 && !p2) begin
      if (sel) r = r & lat;
      for (int i = 0; i < NE; i++) if (en[i]) r = r & val[i*W +: W];
    end
    return r;
  endfunction

  // Drive one cycle, check the combinational outputs, then advance the model past the edge.
  task automatic step(input string tag);
    logic [W-1:0] edb;
    #1;
    edb = exp_bus(phi1, phi2, sel_data, m_in, ext_db_en, ext_db_val);
    chk({tag, " R2 R9 lo bus"}, 32'(lo_addr_bus),
        32'(exp_bus(phi1, phi2, sel_lo_addr, m_in, ext_lo_en, ext_lo_val)));
    chk({tag, " R3 R9 hi bus"}, 32'(hi_addr_bus),
        32'(exp_bus(phi1, phi2, sel_hi_addr, m_in, ext_hi_en, ext_hi_val)));
    chk({tag, " R4 R8 data bus"}, 32'(data_bus), 32'(edb));
    chk({tag, " R6 pad_oe"}, 32'(pad_oe), 32'(phi2 && !pad_rw));
    chk({tag, " R5 R6 R7 pad_data_out"}, 32'(pad_data_out), 32'(m_out));
    if (phi1) m_out = edb;
    if (phi2) m_in = pad_data_in;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    phi1 = 0; phi2 = 0; sel_lo_addr = 0; sel_hi_addr = 0; sel_data = 0;
    ext_lo_en = '0; ext_hi_en = '0; ext_db_en = '0; pad_rw = 1;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog R10 actual=hang expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_in = '0; m_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents of both registers, latch observed on all buses
    chk("R1 out reg reset", 32'(pad_data_out), 32'h0);
    phi1 = 1; sel_data = 1; sel_lo_addr = 1; sel_hi_addr = 1;
    #1;
    chk("R1 latch reset on bus", 32'(data_bus), 32'h0);
    chk("R1 latch reset lo bus", 32'(lo_addr_bus), 32'h0);
    @(negedge clk);
    idle_inputs();

    // R7 capture then R2/R3/R4 spread, R5 load
    phi2 = 1; pad_data_in = 8'hA5; pad_rw = 0; step("dir write");
    idle_inputs(); phi1 = 1; sel_lo_addr = 1; step("dir lo");
    idle_inputs(); phi1 = 1; sel_hi_addr = 1; step("dir hi");
    idle_inputs(); phi1 = 1; sel_data = 1; step("dir db");
    idle_inputs(); step("dir idle");
    chk("R5 out reg holds latch", 32'(pad_data_out), 32'hA5);

    // R9: three-way AND and no-source case
    idle_inputs(); phi1 = 1; sel_data = 1; ext_db_en = 2'b11;
    ext_db_val = {8'hF0, 8'h3C}; step("dir and3");
    idle_inputs(); phi1 = 1; ext_db_val = 8'h00; step("dir none");

    // R8: all strobes during phi2 leave precharge
    idle_inputs(); phi2 = 1; sel_lo_addr = 1; sel_hi_addr = 1; sel_data = 1;
    ext_lo_en = '1; ext_hi_en = '1; ext_db_en = '1; pad_data_in = 8'h5A; step("dir precharge");

    // R10: idle cycles ignore pins and strobes
    idle_inputs(); pad_data_in = 8'h00; sel_data = 1; ext_db_en = '1; ext_db_val = '0; step("dir idle ign");
    idle_inputs(); phi1 = 1; sel_data = 1; step("R10 latch kept");

    for (int n = 0; n < 600; n++) begin
      int ph = $urandom_range(0, 2);
      phi1 = (ph == 1); phi2 = (ph == 2);
      pad_rw = 1'($urandom);
      sel_lo_addr = 1'($urandom); sel_hi_addr = 1'($urandom); sel_data = 1'($urandom);
      ext_lo_en = NE'($urandom); ext_hi_en = NE'($urandom); ext_db_en = NE'($urandom);
      ext_lo_val = (NE*W)'({$urandom, $urandom} | {$urandom, $urandom});
      ext_hi_val = (NE*W)'({$urandom, $urandom} | {$urandom, $urandom});
      ext_db_val = (NE*W)'({$urandom, $urandom} | {$urandom, $urandom});
      pad_data_in = W'($urandom);
      step("rnd");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule